// File: doc/BRIEF.md
# Divide exponent bounce predictor

This block makes an early, conservative call on whether a floating-point divide could leave the normal exponent range, so that the operation can be handed to a software handler instead of being finished by the hardware datapath. It looks only at the biased exponents of the dividend and the divisor, a precision select and an operation select. Significand values, rounding and the classification of special operands are handled elsewhere and are assumed to be dealt with already.

The predictor forms one initial quotient exponent, `exp_a - exp_b + 1023`, in a signed 13-bit value. This is the double-precision bias. A single-precision operation uses the same sum, because its exponents lie in the same domain once 0x380 is added. The sum is then compared against one pair of limits per precision. The upper limit is the same window used for add and subtract overflow. The lower limit also includes the smallest normal exponent. This leaves room for the single one-bit normalising left shift a quotient may need; the quotient significand can never overflow. Square root can neither overflow nor underflow, so it never bounces.

Requests enter and results leave on valid/ready handshakes through one register stage. A request is accepted on a rising edge where `in_valid` and `in_ready` are both high. `in_ready` is high whenever the output register is empty or is being drained in that same cycle. While `out_valid` is high and `out_ready` is low, the result is held unchanged and no new request is taken. The upstream side must keep its request stable until it is accepted.

Top module: `divx_bounce_predict`

## Requirements
- R1: The quotient exponent is `exp_a - exp_b + 1023`, formed without wraparound over the whole input range. Two extreme double-precision pairs both bounce: 0x7FF with 0x000, and 0x000 with 0x7FF. Equal exponents give 0x3FF, which does not bounce.
- R2: For double precision (`in_dp`=1), a quotient exponent of 0x7FD or above bounces. This includes 0x7FE, 0x7FF and values above 0x7FF. A quotient exponent of 0x7FC does not bounce.
- R3: For double precision, a quotient exponent of 0x001 or below bounces. This includes 0x000 and negative values. A quotient exponent of 0x002 does not bounce.
- R4: For single precision (`in_dp`=0), the single-biased quotient exponent is `exp_a - exp_b + 127`. A value of 0xFD or above bounces, and this includes values above 0xFF. A value of 0xFC does not bounce.
- R5: For single precision, a single-biased quotient exponent of 0x01 or below bounces. This includes 0x00 and negative values. A value of 0x02 does not bounce.
- R6: When `in_sqrt`=1, the result never bounces, whatever the exponents and precision.
- R7: In single precision, only bits [7:0] of each exponent port are used. Bits [10:8] have no effect on the result.
- R8: A request accepted on a rising edge appears on `out_valid`/`out_bounce` right after that edge, one cycle of latency. Results leave in the order their requests were accepted.
- R9: `in_ready` equals `!out_valid || out_ready`. While `out_valid`=1 and `out_ready`=0, `out_valid` stays high and `out_bounce` stays unchanged.
- R10: During and right after reset, `out_valid`=0, `out_bounce`=0 and `in_ready`=1.
- R11: `out_bounce` is 0 whenever `out_valid` is 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Synchronous reset, active low |
| in_valid | input | 1 | Request valid |
| in_ready | output | 1 | Request can be accepted this cycle |
| in_exp_a | input | 11 | Biased dividend exponent (single precision uses bits [7:0]) |
| in_exp_b | input | 11 | Biased divisor exponent (single precision uses bits [7:0]) |
| in_dp | input | 1 | 1 = double precision, 0 = single precision |
| in_sqrt | input | 1 | 1 = square root, 0 = divide |
| out_valid | output | 1 | Result valid |
| out_ready | input | 1 | Downstream takes the result this cycle |
| out_bounce | output | 1 | Operation must go to the software handler |

## Verification
The hardest situation to reach from the ports is a result that must be held for several cycles under back-pressure while the next request waits upstream. Only then do the hold rule and the combinational ready path both matter at once. The stimulus reaches it with a long stream of random exponent pairs, while `out_ready` is toggled pseudo-randomly every cycle. Each result is compared in acceptance order, and the held value is checked for stability on every stalled cycle. Every threshold boundary is also driven directly in both precisions. The divisor is chosen so that the quotient exponent lands exactly on each limit and on the value just inside it.

// File: rtl/divx_pkg.sv
package divx_pkg;

  typedef enum logic {
    PREC_SINGLE = 1'b0,
    PREC_DOUBLE = 1'b1
  } prec_e;

  // Bias of an exponent field of the given width
  function automatic int field_bias(input int width);
    return (1 << (width - 1)) - 1;
  endfunction

  // Lowest biased exponent that is flagged high: two below all-ones
  function automatic int high_limit(input int width);
    return (1 << width) - 3;
  endfunction

  // Highest biased exponent that is flagged low: the minimum normal
  function automatic int low_limit();
    return 1;
  endfunction

endpackage

// File: rtl/divx_qexp.sv
module divx_qexp #(
  parameter int EXP_W    = 11,
  parameter int SP_EXP_W = 8,
  parameter int Q_W      = EXP_W + 2
) (
  input  logic [EXP_W-1:0]        exp_a,
  input  logic [EXP_W-1:0]        exp_b,
  input  logic                    dp,
  output logic signed [Q_W-1:0]   q_exp
);
  import divx_pkg::*;

  localparam int EXT_W = Q_W - EXP_W;
  localparam int BIAS  = field_bias(EXP_W);
  localparam logic [EXP_W-1:0] SP_MASK = EXP_W'((1 << SP_EXP_W) - 1);

  logic [EXP_W-1:0]      a_eff, b_eff;
  logic signed [Q_W-1:0] ea, eb;

  // Single precision reads only the narrow field of each port
  always_comb begin
    a_eff = (dp == PREC_DOUBLE) ? exp_a : (exp_a & SP_MASK);
    b_eff = (dp == PREC_DOUBLE) ? exp_b : (exp_b & SP_MASK);
    ea    = $signed({{EXT_W{1'b0}}, a_eff});
    eb    = $signed({{EXT_W{1'b0}}, b_eff});
    q_exp = ea - eb + $signed(Q_W'(BIAS));
  end

endmodule

// File: rtl/divx_window.sv
module divx_window #(
  parameter int EXP_W    = 11,
  parameter int SP_EXP_W = 8,
  parameter int Q_W      = EXP_W + 2
) (
  input  logic signed [Q_W-1:0] q_exp,
  input  logic                  dp,
  input  logic                  sqrt_op,
  output logic                  bounce
);
  import divx_pkg::*;

  localparam int SHIFT = field_bias(EXP_W) - field_bias(SP_EXP_W);

  logic [1:0] over, under;

  // One limit pair per precision, both expressed in the wide-biased domain
  for (genvar p = 0; p < 2; p++) begin : g_prec
    localparam int W   = (p == 1) ? EXP_W : SP_EXP_W;
    localparam int OFF = (p == 1) ? 0 : SHIFT;
    localparam logic signed [Q_W-1:0] HI = Q_W'(high_limit(W) + OFF);
    localparam logic signed [Q_W-1:0] LO = Q_W'(low_limit() + OFF);
    assign over[p]  = (q_exp >= HI);
    assign under[p] = (q_exp <= LO);
  end

  always_comb begin
    bounce = 1'b0;
    if (!sqrt_op) bounce = over[dp] | under[dp];
  end

endmodule

// File: rtl/divx_outreg.sv
module divx_outreg (
  input  logic clk,
  input  logic rst_n,
  input  logic in_valid,
  output logic in_ready,
  input  logic in_bounce,
  output logic out_valid,
  input  logic out_ready,
  output logic out_bounce
);

  assign in_ready = !out_valid || out_ready;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      out_valid  <= 1'b0;
      out_bounce <= 1'b0;
    end else if (in_ready) begin
      out_valid  <= in_valid;
      out_bounce <= in_valid & in_bounce;
    end
  end

  a_r8_accept_gives_result: assert property (@(posedge clk) disable iff (!rst_n)
    (in_valid && in_ready) |=> out_valid);

  a_r9_hold_when_stalled: assert property (@(posedge clk) disable iff (!rst_n)
    (out_valid && !out_ready) |=> (out_valid && $stable(out_bounce)));

  a_r11_quiet_when_idle: assert property (@(posedge clk) disable iff (!rst_n)
    !out_valid |-> !out_bounce);

endmodule

// File: rtl/divx_bounce_predict.sv
module divx_bounce_predict #(
  parameter int EXP_W    = 11,
  parameter int SP_EXP_W = 8
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             in_valid,
  output logic             in_ready,
  input  logic [EXP_W-1:0] in_exp_a,
  input  logic [EXP_W-1:0] in_exp_b,
  input  logic             in_dp,
  input  logic             in_sqrt,
  output logic             out_valid,
  input  logic             out_ready,
  output logic             out_bounce
);

  localparam int Q_W = EXP_W + 2;

  logic signed [Q_W-1:0] q_exp;
  logic                  bounce_c;

  divx_qexp #(.EXP_W(EXP_W), .SP_EXP_W(SP_EXP_W), .Q_W(Q_W)) u_qexp (
    .exp_a (in_exp_a),
    .exp_b (in_exp_b),
    .dp    (in_dp),
    .q_exp (q_exp)
  );

  divx_window #(.EXP_W(EXP_W), .SP_EXP_W(SP_EXP_W), .Q_W(Q_W)) u_window (
    .q_exp   (q_exp),
    .dp      (in_dp),
    .sqrt_op (in_sqrt),
    .bounce  (bounce_c)
  );

  divx_outreg u_outreg (
    .clk        (clk),
    .rst_n      (rst_n),
    .in_valid   (in_valid),
    .in_ready   (in_ready),
    .in_bounce  (bounce_c),
    .out_valid  (out_valid),
    .out_ready  (out_ready),
    .out_bounce (out_bounce)
  );

  a_r6_root_never_bounces: assert property (@(posedge clk) disable iff (!rst_n)
    (in_valid && in_ready && in_sqrt) |=> !out_bounce);

  a_r1_top_minus_zero: assert property (@(posedge clk) disable iff (!rst_n)
    (in_valid && in_ready && in_dp && !in_sqrt && (&in_exp_a) && (in_exp_b == '0))
      |=> out_bounce);

  a_r1_zero_minus_top: assert property (@(posedge clk) disable iff (!rst_n)
    (in_valid && in_ready && in_dp && !in_sqrt && (in_exp_a == '0) && (&in_exp_b))
      |=> out_bounce);

endmodule

// File: tb/divx_bounce_predict_test.sv
module divx_bounce_predict_test;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        in_valid = 1'b0;
  logic        in_ready;
  logic [10:0] in_exp_a = '0;
  logic [10:0] in_exp_b = '0;
  logic        in_dp = 1'b0;
  logic        in_sqrt = 1'b0;
  logic        out_valid;
  logic        out_ready = 1'b1;
  logic        out_bounce;

  int  checks = 0;
  int  failures = 0;
  bit  exp_q[$];
  string tag_q[$];
  bit  bp_en = 1'b0;
  bit  done = 1'b0;

  always #10 clk = ~clk;  // 50 MHz

  divx_bounce_predict uut (
    .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .in_ready(in_ready),
    .in_exp_a(in_exp_a), .in_exp_b(in_exp_b), .in_dp(in_dp), .in_sqrt(in_sqrt),
    .out_valid(out_valid), .out_ready(out_ready), .out_bounce(out_bounce)
  );

  task automatic check(input string req, input int act, input int expv, input string what);
    checks++;
    if (act != expv) begin
      failures++;
      $display("FAIL %s %s actual=%0d expected=%0d", req, what, act, expv);
    end
  endtask

  function automatic bit model(input logic [10:0] a, input logic [10:0] b,
                               input bit dp, input bit sq);
    int q;
    if (sq) return 1'b0;
    if (dp) begin
      q = int'(a) - int'(b) + 1023;
      return (q >= 2045) || (q <= 1);
    end
    q = int'(a[7:0]) - int'(b[7:0]) + 127;
    return (q >= 253) || (q <= 1);
  endfunction

  // Driver: present at a falling edge, hold until accepted
  task automatic drive(input logic [10:0] a, input logic [10:0] b,
                       input bit dp, input bit sq, input string tag);
    @(negedge clk);
    in_exp_a = a; in_exp_b = b; in_dp = dp; in_sqrt = sq; in_valid = 1'b1;
    #1;
    while (!in_ready) begin
      @(negedge clk);
      #1;
    end
    exp_q.push_back(model(a, b, dp, sq));
    tag_q.push_back(tag);
    @(negedge clk);
    in_valid = 1'b0;
  endtask

  task automatic finish_run();
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  endtask

  // Monitor / scoreboard, sampling 2 ns after the falling edge
  initial begin
    bit held_v = 1'b0;
    bit held_b = 1'b0;
    forever begin
      @(negedge clk);
      #2;
      if (rst_n) begin
        if (held_v) begin
          check("R9", out_valid, 1, "held valid");
          check("R9", out_bounce, held_b, "held bounce");
        end
        check("R9", in_ready, (!out_valid || out_ready) ? 1 : 0, "in_ready");
        if (!out_valid) check("R11", out_bounce, 0, "bounce while idle");
        if (out_valid && out_ready) begin
          if (exp_q.size() == 0) begin
            check("R8", 1, 0, "unexpected result");
          end else begin
            bit e;
            string t;
            e = exp_q.pop_front();
            t = tag_q.pop_front();
            check(t, out_bounce, e, "bounce");
          end
        end
        held_v = out_valid && !out_ready;
        held_b = out_bounce;
      end
    end
  end

  // Back-pressure generator
  initial begin
    forever begin
      @(negedge clk);
      out_ready = bp_en ? ($urandom_range(0, 2) != 0) : 1'b1;
    end
  end

  // Watchdog
  initial begin
    repeat (100000) @(posedge clk);
    if (!done) begin
      failures++;
      $display("FAIL R8 watchdog actual=hung expected=done");
      finish_run();
    end
  end

  initial begin
    repeat (3) @(negedge clk);
    #2;
    check("R10", out_valid, 0, "valid in reset");
    check("R10", out_bounce, 0, "bounce in reset");
    @(negedge clk);
    rst_n = 1'b1;
    #2;
    check("R10", out_valid, 0, "valid after reset");
    check("R10", out_bounce, 0, "bounce after reset");
    check("R10", in_ready, 1, "ready after reset");

    // R8: explicit one-cycle latency
    @(negedge clk);
    in_exp_a = 11'h7FD; in_exp_b = 11'h3FF; in_dp = 1'b1; in_sqrt = 1'b0; in_valid = 1'b1;
    exp_q.push_back(1'b1); tag_q.push_back("R8");
    @(negedge clk);
    in_valid = 1'b0;
    #1;
    check("R8", out_valid, 1, "valid one cycle after accept");

    // R2 double upper limit (divisor 0x3FF so quotient equals dividend)
    drive(11'h7FC, 11'h3FF, 1, 0, "R2");
    drive(11'h7FD, 11'h3FF, 1, 0, "R2");
    drive(11'h7FE, 11'h3FF, 1, 0, "R2");
    drive(11'h7FF, 11'h3FF, 1, 0, "R2");
    drive(11'h7FF, 11'h3FE, 1, 0, "R2");
    // R3 double lower limit
    drive(11'h002, 11'h3FF, 1, 0, "R3");
    drive(11'h001, 11'h3FF, 1, 0, "R3");
    drive(11'h000, 11'h3FF, 1, 0, "R3");
    drive(11'h000, 11'h400, 1, 0, "R3");
    // R1 extremes
    drive(11'h7FF, 11'h000, 1, 0, "R1");
    drive(11'h000, 11'h7FF, 1, 0, "R1");
    drive(11'h400, 11'h400, 1, 0, "R1");
    // R4 single upper limit (divisor 0x7F so quotient equals dividend)
    drive(11'h0FC, 11'h07F, 0, 0, "R4");
    drive(11'h0FD, 11'h07F, 0, 0, "R4");
    drive(11'h0FE, 11'h07F, 0, 0, "R4");
    drive(11'h0FF, 11'h07F, 0, 0, "R4");
    drive(11'h0FF, 11'h07E, 0, 0, "R4");
    drive(11'h0FF, 11'h000, 0, 0, "R4");
    // R5 single lower limit
    drive(11'h002, 11'h07F, 0, 0, "R5");
    drive(11'h001, 11'h07F, 0, 0, "R5");
    drive(11'h000, 11'h07F, 0, 0, "R5");
    drive(11'h000, 11'h080, 0, 0, "R5");
    drive(11'h000, 11'h0FF, 0, 0, "R5");
    // R7 upper field bits ignored in single precision
    drive(11'h702, 11'h07F, 0, 0, "R7");
    drive(11'h0FC, 11'h77F, 0, 0, "R7");
    drive(11'h501, 11'h27F, 0, 0, "R7");
    // R6 square root never bounces
    drive(11'h7FF, 11'h000, 1, 1, "R6");
    drive(11'h000, 11'h7FF, 1, 1, "R6");
    drive(11'h0FF, 11'h000, 0, 1, "R6");
    drive(11'h000, 11'h0FF, 0, 1, "R6");

    // Random stream under back-pressure (R8 ordering, R9 hold)
    bp_en = 1'b1;
    for (int i = 0; i < 400; i++) begin
      logic [10:0] a, b;
      bit dp, sq;
      a  = 11'($urandom_range(0, 2047));
      b  = 11'($urandom_range(0, 2047));
      dp = 1'($urandom_range(0, 1));
      sq = ($urandom_range(0, 7) == 0);
      if (i % 3 == 0) b = dp ? 11'h3FF - 11'($urandom_range(0, 3)) : 11'h07F;
      drive(a, b, dp, sq, dp ? "R2" : "R4");
    end
    bp_en = 1'b0;
    repeat (10) @(negedge clk);
    #3;
    check("R8", exp_q.size(), 0, "results outstanding");
    done = 1'b1;
    finish_run();
  end

endmodule